// File: doc/BRIEF.md
# Busy-Gated Live Trigger Latch

This block sits between the coincidence logic of a multi-crate acquisition system and the readout controllers. Each rising edge of the raw trigger input is judged against the current state of every readout partner. If no partner reports busy, no partner is still working on an earlier event, and the run is enabled, the edge sets a latch. The latch output is the live trigger sent to all partners.

The latch stays set until the OR of all partner busy lines falls. The live trigger therefore lasts as long as the slowest readout, and the rest of the system can treat it as a global busy flag.

Raw edges that arrive while the run is disabled, or while a partner is busy or still processing an event, are rejected. Each rejection gives a single-cycle strobe that a scaler can count. All inputs are asynchronous and pass through a synchronizer of parameterised depth before any edge is detected.

Top module: `live_trigger_gate`

## Requirements
- R1: With every busy and pending line low, the run enable high and the latch clear, a rising edge on `raw_trig_i` sets `live_o`. With the default two-stage synchronizer, an input change becomes visible at the outputs after the third rising clock edge.
- R2: Once set, `live_o` stays high while any bit of `busy_i` is high. It returns low after the OR of `busy_i` falls, with the same three-edge latency.
- R3: When several busy lines are high, `live_o` stays high until the last of them drops, whatever order they drop in.
- R4: A raw rising edge that arrives while any bit of `busy_i` is high, with the latch clear, leaves `live_o` low.
- R5: A raw rising edge that arrives while any bit of `eoe_pend_i` is high leaves `live_o` low. A high bit means that partner has not yet returned its end-of-event.
- R6: A raw rising edge that arrives while `run_en_i` is low leaves `live_o` low.
- R7: A raw rising edge that arrives while `live_o` is already high is ignored. It produces no veto strobe, and `live_o` still clears at the next fall of the busy OR.
- R8: Each raw edge that is rejected under R4, R5 or R6 produces exactly one single-cycle high pulse on `veto_pulse_o`. Accepted edges produce none.
- R9: If a raw rising edge and a fall of the busy OR reach the decision logic in the same cycle, the outcome depends on the latch. A clear latch accepts the edge and sets `live_o`. A set latch clears and ignores the edge.
- R10: After reset, `live_o` and `veto_pulse_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_trig_i | input | 1 | Raw coincidence trigger, asynchronous |
| busy_i | input | N_PART | Per-partner readout busy, asynchronous |
| eoe_pend_i | input | N_PART | Per-partner event pending (end-of-event not yet returned), asynchronous |
| run_en_i | input | 1 | Run enable, asynchronous |
| live_o | output | 1 | Live trigger / global busy latch |
| veto_pulse_o | output | 1 | One-cycle strobe per rejected raw trigger |

## Verification
Two functions can meet in one cycle: the setting of the latch by a raw edge and its clearing by a fall of the busy OR. The bench provokes this by changing both inputs at the same instant, so that after synchronization both arrive in the same cycle.

The collision is run twice. In the first run the latch is clear and the busy is a scaler-only readout; here the edge must be accepted. In the second run the latch is set; here it must clear with no veto strobe. Both outcomes are judged at the ports three edges later.

All 128 combinations of busy, pending and enable are also swept for the default three-partner configuration.

// File: rtl/trig_gate_pkg.sv
package trig_gate_pkg;

  typedef enum logic [1:0] {
    DEC_IDLE   = 2'd0,
    DEC_ACCEPT = 2'd1,
    DEC_VETO   = 2'd2,
    DEC_IGNORE = 2'd3
  } trig_dec_e;

  // Decide what a raw edge does given latch state and inhibit condition
  function automatic trig_dec_e classify(input logic rise, input logic latched,
                                         input logic inhibit);
    if (!rise)        return DEC_IDLE;
    else if (latched) return DEC_IGNORE;
    else if (inhibit) return DEC_VETO;
    else              return DEC_ACCEPT;
  endfunction

endpackage

// File: rtl/tg_sync.sv
module tg_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/tg_edge.sv
module tg_edge #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  generate
    if (FALLING) begin : g_fall
      assign pulse_o = prev_q & ~lvl_i;
    end else begin : g_rise
      assign pulse_o = ~prev_q & lvl_i;
    end
  endgenerate
endmodule

// File: rtl/tg_latch.sv
module tg_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
endmodule

// File: rtl/live_trigger_gate.sv
module live_trigger_gate
  import trig_gate_pkg::*;
#(
  parameter int N_PART      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_trig_i,
  input  logic [N_PART-1:0] busy_i,
  input  logic [N_PART-1:0] eoe_pend_i,
  input  logic              run_en_i,
  output logic              live_o,
  output logic              veto_pulse_o
);
  localparam int SYNC_W = 2 * N_PART + 2;

  logic [SYNC_W-1:0] async_bus, sync_bus;
  logic [N_PART-1:0] busy_s, eoe_s;
  logic raw_s, run_s;
  logic busy_any, eoe_any, inhibit;
  logic raw_rise, busy_fall;
  trig_dec_e dec;
  logic set_ev, veto_ev;

  assign async_bus = {run_en_i, raw_trig_i, eoe_pend_i, busy_i};

  tg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(async_bus), .q_o(sync_bus));

  assign busy_s = sync_bus[N_PART-1:0];
  assign eoe_s  = sync_bus[2*N_PART-1:N_PART];
  assign raw_s  = sync_bus[2*N_PART];
  assign run_s  = sync_bus[2*N_PART+1];

  assign busy_any = |busy_s;
  assign eoe_any  = |eoe_s;
  assign inhibit  = busy_any | eoe_any | ~run_s;

  tg_edge #(.FALLING(1'b0)) u_raw_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(raw_s), .pulse_o(raw_rise));

  tg_edge #(.FALLING(1'b1)) u_busy_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(busy_any), .pulse_o(busy_fall));

  assign dec     = classify(raw_rise, live_o, inhibit);
  assign set_ev  = (dec == DEC_ACCEPT);
  assign veto_ev = (dec == DEC_VETO);

  tg_latch u_latch (
    .clk(clk), .rst_n(rst_n), .set_i(set_ev), .clr_i(busy_fall), .q_o(live_o));

  always_ff @(posedge clk) begin
    if (!rst_n) veto_pulse_o <= 1'b0;
    else        veto_pulse_o <= veto_ev;
  end

  // R1
  accept_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_rise && !inhibit && !live_o) |=> live_o);
  // R2
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_o && busy_any) |=> live_o);
  // R4
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_rise && busy_any && !live_o) |=> (!live_o && veto_pulse_o));
  // R5
  pend_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_rise && eoe_any && !live_o) |=> !live_o);
  // R6
  run_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_rise && !run_s && !live_o) |=> !live_o);
  // R7
  ignore_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_rise && live_o) |=> !veto_pulse_o);
  // R8
  veto_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    veto_pulse_o |=> !veto_pulse_o);
  // R8
  veto_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(veto_pulse_o && $rose(live_o)));
endmodule

// File: tb/live_trigger_gate_bench.sv
`timescale 1ns/1ps
module live_trigger_gate_bench;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw = 1'b0;
  logic [N-1:0] busy = '0;
  logic [N-1:0] pend = '0;
  logic run = 1'b0;
  logic live, veto;

  int checks = 0;
  int errors = 0;
  int vcnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  live_trigger_gate #(.N_PART(N), .SYNC_STAGES(2)) u_live_trigger_gate (
    .clk(clk), .rst_n(rst_n), .raw_trig_i(raw), .busy_i(busy),
    .eoe_pend_i(pend), .run_en_i(run), .live_o(live), .veto_pulse_o(veto));

  always @(negedge clk) if (rst_n && veto) vcnt++;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_raw();
    raw = 1'b1; cyc(2); raw = 1'b0; cyc(4);
  endtask

  task automatic arm();
    busy = '0; pend = '0; run = 1'b1; cyc(4);
    pulse_raw();
  endtask

  task automatic release_latch();
    busy = 3'b001; cyc(4); busy = '0; cyc(4);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    check(live == 1'b0, "R10 live", live, 0);
    check(veto == 1'b0, "R10 veto", veto, 0);
    rst_n = 1'b1;
    cyc(3);

    // Sweep: R1 R4 R5 R6 R8
    for (int b = 0; b < 8; b++) begin
      for (int e = 0; e < 8; e++) begin
        for (int r = 0; r < 2; r++) begin
          int v0;
          bit acc;
          string tag;
          busy = b[N-1:0]; pend = e[N-1:0]; run = r[0];
          cyc(4);
          v0 = vcnt;
          pulse_raw();
          acc = (b == 0) && (e == 0) && (r == 1);
          tag = (b != 0) ? "R4" : (e != 0) ? "R5" : (r == 0) ? "R6" : "R1";
          check(live == acc, tag, live, acc);
          check((vcnt - v0) == (acc ? 0 : 1), "R8 veto count", vcnt - v0, acc ? 0 : 1);
          if (live) begin
            busy = '0; pend = '0;
            busy = 3'b100; cyc(4);
            check(live == 1'b1, "R2 hold", live, 1);
            busy = '0; cyc(4);
            check(live == 1'b0, "R2 clear", live, 0);
          end
        end
      end
    end

    // R3: longest busy, three drop orders
    for (int k = 0; k < N; k++) begin
      arm();
      busy = '1; cyc(4);
      for (int j = 0; j < N; j++) begin
        busy[(k + j) % N] = 1'b0; cyc(4);
        check(live == (j != N - 1), "R3 longest busy", live, (j != N - 1));
      end
    end

    // R7: retrigger while latched with busy high
    begin
      int v0;
      arm();
      busy = 3'b010; cyc(4);
      v0 = vcnt;
      pulse_raw();
      check(vcnt == v0, "R7 no veto", vcnt - v0, 0);
      check(live == 1'b1, "R7 still live", live, 1);
      busy = '0; cyc(4);
      check(live == 1'b0, "R7 no extension", live, 0);
    end

    // R7: retrigger while latched before busy appears
    begin
      int v0;
      arm();
      v0 = vcnt;
      pulse_raw();
      check(vcnt == v0, "R7 no veto idle", vcnt - v0, 0);
      release_latch();
      check(live == 1'b0, "R7 clears on first fall", live, 0);
    end

    // R9: collision with clear latch (scaler-only busy)
    begin
      int v0;
      run = 1'b1; pend = '0; busy = 3'b001; cyc(4);
      check(live == 1'b0, "R9 pre", live, 0);
      v0 = vcnt;
      busy = '0; raw = 1'b1; cyc(2); raw = 1'b0; cyc(4);
      check(live == 1'b1, "R9 accept on fall", live, 1);
      check(vcnt == v0, "R9 no veto", vcnt - v0, 0);
      release_latch();
    end

    // R9: collision with set latch
    begin
      int v0;
      arm();
      busy = 3'b100; cyc(4);
      v0 = vcnt;
      busy = '0; raw = 1'b1; cyc(2); raw = 1'b0; cyc(4);
      check(live == 1'b0, "R9 clear wins when latched", live, 0);
      check(vcnt == v0, "R9 ignored edge", vcnt - v0, 0);
    end

    // R1: three-edge latency
    begin
      busy = '0; pend = '0; run = 1'b1; cyc(4);
      raw = 1'b1;
      cyc(2);
      check(live == 1'b0, "R1 not before third edge", live, 0);
      cyc(1);
      check(live == 1'b1, "R1 after third edge", live, 1);
      raw = 1'b0; cyc(2);
      release_latch();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule